// File: doc/BRIEF.md
# Stereo Serial Audio Port (I2S, master or slave)

This block moves stereo audio between a parallel sample interface and a three-wire I2S serial link. Each frame holds a 16-bit left sample followed by a 16-bit right sample. A single mode input picks which side owns the link clocks.

In master mode the port runs from a system clock at 256 times the sample rate. It divides that clock down to a bit clock (32 per frame) and a word clock (one period per frame), and forwards the system clock as the master clock. In slave mode the bit and word clocks come from outside. They pass through synchronizers into the system clock domain, and the master clock output enable is driven low.

Transmit pairs arrive through a valid/ready handshake and wait in a one-pair holding register until the next frame starts. Received pairs leave through a valid/ready handshake. If no fresh transmit pair is waiting when a frame starts, the port resends the previous pair and raises a sticky underrun flag.

Top module: `i2s_port`

## Requirements
- R1: In master mode the bit clock period is 8 system clocks, and the word clock period is 256 system clocks with 128 of them high. Every word clock transition coincides with a bit clock falling edge. mclkOe is high.
- R2: In slave mode mclkOe is low, and bclkOut and lrckOut stay low.
- R3: Word clock low carries the left sample and high carries the right sample. Each sample is sent MSB first, and the MSB occupies the bit slot that follows the word clock transition. The slot in which the word clock falls carries the previous right sample's LSB.
- R4: Serial output changes only on bit clock falling edges, and serial input is sampled on rising edges. In master mode a loopback from sdOut to sdIn returns every transmitted pair unchanged.
- R5: txReady is high while the holding register is empty. A pair is taken on a cycle with txValid and txReady both high, after which txReady goes low until the next frame start consumes the pair.
- R6: When a frame starts with the holding register empty, the frame repeats the last accepted pair (zero after reset) and underrun is set. underrun stays set until reset.
- R7: After each complete received frame, rxValid rises with rxLeft/rxRight holding that frame. rxValid and the data hold until rxReady is seen. The partial frame in progress when the link starts is discarded.
- R8: In slave mode, with external clocks of 32 bit clocks per frame and 8 system clocks per bit, the pairs on sdIn are delivered correctly. The first full frame after the first word clock fall is the first pair delivered.
- R9: During and right after reset: rxValid and underrun are low, txReady is high, and the clock outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 × sample rate in master mode |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = port generates link clocks, 0 = link clocks are inputs |
| bclkIn | input | 1 | External bit clock (slave mode) |
| lrckIn | input | 1 | External word clock (slave mode) |
| sdIn | input | 1 | Serial receive data |
| bclkOut | output | 1 | Generated bit clock (master mode) |
| lrckOut | output | 1 | Generated word clock (master mode) |
| mclkOut | output | 1 | Forwarded master clock |
| mclkOe | output | 1 | Output enable for mclkOut, low in slave mode |
| sdOut | output | 1 | Serial transmit data |
| txValid | input | 1 | Transmit pair offered |
| txReady | output | 1 | Holding register empty |
| txLeft | input | 16 | Left transmit sample |
| txRight | input | 16 | Right transmit sample |
| rxValid | output | 1 | Received pair available |
| rxReady | input | 1 | Consumer takes the received pair |
| rxLeft | output | 16 | Left received sample |
| rxRight | output | 16 | Right received sample |
| underrun | output | 1 | Sticky flag: a frame started with no fresh transmit pair |

## Verification
The bench decodes the serial stream bit by bit from the pins rather than trusting loopback alone. A design that reversed the bit order, or dropped the one-slot MSB delay, would still pass loopback but would fail the per-frame decode. It then stops feeding transmit pairs. A design that zeroed or kept shifting stale data would fail the checks on the repeated pair and on the sticky flag, and so would one that set the flag too early. In slave mode it holds rxReady low to catch a port that drops or overwrites a pair the consumer has not taken. It starts the external clocks with a high word clock, so that a port which mistakes the start-up partial frame for real data delivers the wrong first pair.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;
  // Timing strobes from the clock control to the datapath, one system cycle wide.
  typedef struct packed {
    logic bitFall;     // bit clock falls this cycle: shift out the next bit
    logic bitRise;     // bit clock rises this cycle: sample the input bit
    logic frameStart;  // word clock went low at this fall: left channel begins
  } i2sStrobe_t;
endpackage

// File: rtl/i2s_clk_ctrl.sv
module i2s_clk_ctrl
  import i2s_port_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int BCLK_DIV    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterMode,
  input  logic       bclkIn,
  input  logic       lrckIn,
  input  logic       sdIn,
  output logic       bclkOut,
  output logic       lrckOut,
  output logic       mclkOe,
  output logic       sdBit,
  output i2sStrobe_t stb
);
  localparam int FRAME_BITS = 2 * SAMPLE_W;
  localparam int CNT_W      = $clog2(BCLK_DIV * FRAME_BITS);
  localparam int PH_W       = $clog2(BCLK_DIV);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(BCLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(BCLK_DIV / 2 - 1);

  // Master timing: one counter spans a whole frame.
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (masterMode) cnt <= cnt + 1'b1;
    else                 cnt <= '0;
  end

  i2sStrobe_t mStb, sStb;
  assign mStb.bitFall    = (cnt[PH_W-1:0] == PH_FALL);
  assign mStb.bitRise    = (cnt[PH_W-1:0] == PH_RISE);
  assign mStb.frameStart = mStb.bitFall && (cnt == '1);

  // Slave timing: synchronize bit clock, word clock and data alike.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    logic [2:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= {bclkIn, lrckIn, sdIn};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= g_sync[s-1].q;
      end
    end
  end

  logic [2:0] syncV;
  assign syncV = g_sync[SYNC_STAGES-1].q;

  logic bclkPrev, lrckAtFall;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPrev   <= 1'b0;
      lrckAtFall <= 1'b0;
    end else begin
      bclkPrev <= syncV[2];
      if (sStb.bitFall) lrckAtFall <= syncV[1];
    end
  end

  assign sStb.bitFall    = bclkPrev && !syncV[2];
  assign sStb.bitRise    = !bclkPrev && syncV[2];
  assign sStb.frameStart = sStb.bitFall && !syncV[1] && lrckAtFall;

  assign stb     = masterMode ? mStb : sStb;
  assign sdBit   = masterMode ? sdIn : syncV[0];
  assign bclkOut = masterMode & cnt[PH_W-1];
  assign lrckOut = masterMode & cnt[CNT_W-1];
  assign mclkOe  = masterMode;
endmodule

// File: rtl/i2s_data_path.sv
module i2s_data_path
  import i2s_port_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  i2sStrobe_t          stb,
  input  logic                sdBit,
  input  logic                txValid,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                txReady,
  output logic                sdOut,
  input  logic                rxReady,
  output logic                rxValid,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                underrun
);
  localparam int FRAME_W = 2 * SAMPLE_W;

  logic [FRAME_W-1:0] txHold, txShift, rxShift, rxData, rxNext;
  logic txFull, sdOutQ, frameSeen, rxPending, rxValidQ, underrunQ, txAccept;

  assign txReady  = !txFull;
  assign txAccept = txValid && !txFull;
  assign rxNext   = {rxShift[FRAME_W-2:0], sdBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold    <= '0;
      txShift   <= '0;
      rxShift   <= '0;
      rxData    <= '0;
      txFull    <= 1'b0;
      sdOutQ    <= 1'b0;
      frameSeen <= 1'b0;
      rxPending <= 1'b0;
      rxValidQ  <= 1'b0;
      underrunQ <= 1'b0;
    end else begin
      // Transmit side: the holding register feeds the shifter at frame start.
      if (txAccept) txHold <= {txLeft, txRight};
      if (stb.frameStart)  txFull <= txAccept;
      else if (txAccept)   txFull <= 1'b1;
      if (stb.frameStart && !txFull) underrunQ <= 1'b1;
      if (stb.bitFall) begin
        sdOutQ  <= txShift[FRAME_W-1];
        txShift <= stb.frameStart ? txHold : {txShift[FRAME_W-2:0], 1'b0};
      end
      // Receive side: the frame completes on the first rise after a frame start.
      if (stb.frameStart) begin
        frameSeen <= 1'b1;
        rxPending <= frameSeen;
      end
      if (rxValidQ && rxReady) rxValidQ <= 1'b0;
      if (stb.bitRise) begin
        rxShift <= rxNext;
        if (rxPending) begin
          rxPending <= 1'b0;
          if (!rxValidQ || rxReady) begin
            rxValidQ <= 1'b1;
            rxData   <= rxNext;
          end
        end
      end
    end
  end

  assign sdOut    = sdOutQ;
  assign rxValid  = rxValidQ;
  assign rxLeft   = rxData[FRAME_W-1:SAMPLE_W];
  assign rxRight  = rxData[SAMPLE_W-1:0];
  assign underrun = underrunQ;
endmodule

// File: rtl/i2s_port.sv
module i2s_port
  import i2s_port_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int BCLK_DIV    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterMode,
  input  logic                bclkIn,
  input  logic                lrckIn,
  input  logic                sdIn,
  output logic                bclkOut,
  output logic                lrckOut,
  output logic                mclkOut,
  output logic                mclkOe,
  output logic                sdOut,
  input  logic                txValid,
  output logic                txReady,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                rxValid,
  input  logic                rxReady,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                underrun
);
  i2sStrobe_t stb;
  logic       sdBit;

  i2s_clk_ctrl #(
    .SAMPLE_W(SAMPLE_W), .BCLK_DIV(BCLK_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .bclkIn(bclkIn), .lrckIn(lrckIn), .sdIn(sdIn),
    .bclkOut(bclkOut), .lrckOut(lrckOut), .mclkOe(mclkOe),
    .sdBit(sdBit), .stb(stb)
  );

  i2s_data_path #(.SAMPLE_W(SAMPLE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdBit(sdBit),
    .txValid(txValid), .txLeft(txLeft), .txRight(txRight), .txReady(txReady),
    .sdOut(sdOut), .rxReady(rxReady), .rxValid(rxValid),
    .rxLeft(rxLeft), .rxRight(rxRight), .underrun(underrun)
  );

  assign mclkOut = clk;
endmodule

// File: rtl/i2s_port_chk.sv
module i2s_port_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                masterMode,
  input logic                bclkOut,
  input logic                lrckOut,
  input logic                mclkOe,
  input logic                sdOut,
  input logic                txValid,
  input logic                txReady,
  input logic                rxValid,
  input logic                rxReady,
  input logic [SAMPLE_W-1:0] rxLeft,
  input logic [SAMPLE_W-1:0] rxRight,
  input logic                underrun
);
  p_lrck_on_fall_r1: assert property (@(posedge clk) disable iff (!rstN)
    masterMode && $past(masterMode) && !$stable(lrckOut) |-> $fell(bclkOut));

  p_slave_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode && $past(!masterMode) |-> $stable(bclkOut) && $stable(lrckOut) && !mclkOe);

  p_sd_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    masterMode && $past(masterMode) && !$stable(sdOut) |-> $fell(bclkOut));

  p_tx_take_r5: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady |=> !txReady);

  p_underrun_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);

  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxReady |=> rxValid && $stable(rxLeft) && $stable(rxRight));
endmodule

bind i2s_port i2s_port_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk(clk), .rstN(rstN), .masterMode(masterMode), .bclkOut(bclkOut),
  .lrckOut(lrckOut), .mclkOe(mclkOe), .sdOut(sdOut), .txValid(txValid),
  .txReady(txReady), .rxValid(rxValid), .rxReady(rxReady),
  .rxLeft(rxLeft), .rxRight(rxRight), .underrun(underrun)
);

// File: tb/i2s_port_tb.sv
module i2s_port_tb_top;
  localparam int N_VEC = 5;
  localparam logic [31:0] VEC [N_VEC] = '{
    32'hA5C3_1E0F, 32'h8001_7FFE, 32'hFFFF_0000, 32'h0000_FFFF, 32'h1234_ABCD};
  localparam logic [31:0] SLV [3] = '{32'h9876_0421, 32'h0001_8000, 32'hC3A5_5AC3};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, masterMode, bclkIn, lrckIn, sdInSlave, sdIn;
  logic bclkOut, lrckOut, mclkOut, mclkOe, sdOut;
  logic txValid, txReady, rxValid, rxReady, underrun;
  logic [15:0] txLeft, txRight, rxLeft, rxRight;

  assign sdIn = masterMode ? sdOut : sdInSlave;

  i2s_port dut_i (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .bclkIn(bclkIn),
    .lrckIn(lrckIn), .sdIn(sdIn), .bclkOut(bclkOut), .lrckOut(lrckOut),
    .mclkOut(mclkOut), .mclkOe(mclkOe), .sdOut(sdOut), .txValid(txValid),
    .txReady(txReady), .txLeft(txLeft), .txRight(txRight), .rxValid(rxValid),
    .rxReady(rxReady), .rxLeft(rxLeft), .rxRight(rxRight), .underrun(underrun)
  );

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // Serial monitor for master mode: decodes the pins, independent of the RTL.
  logic bitBuf [512];
  int frameIdx [16];
  int nBits = 0, nFr = 0, cyc = 0;
  int lastBRise = 0, lastLRise = 0, bPer = 0, lPer = 0, lHigh = 0;
  logic prevB = 1'b0, prevL = 1'b0, undAtF4 = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rstN && masterMode) begin
      if (bclkOut && !prevB) begin
        if (nBits < 512) bitBuf[nBits] = sdOut;
        nBits++;
        bPer = cyc - lastBRise;
        lastBRise = cyc;
      end
      if (lrckOut && !prevL) begin
        lPer = cyc - lastLRise;
        lastLRise = cyc;
      end
      if (!lrckOut && prevL) begin
        lHigh = cyc - lastLRise;
        if (nFr < 16) frameIdx[nFr] = nBits;
        nFr++;
        if (nFr == 5) undAtF4 = underrun;
      end
    end
    prevB = bclkOut;
    prevL = lrckOut;
  end

  task automatic push(input logic [31:0] p);
    @(negedge clk);
    txLeft = p[31:16];
    txRight = p[15:0];
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic slot(input logic lr, input logic b);
    bclkIn = 1'b0;
    lrckIn = lr;
    sdInSlave = b;
    repeat (4) @(negedge clk);
    bclkIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  bit genDone = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    logic [31:0] w, held;
    rstN = 1'b0; masterMode = 1'b1; bclkIn = 1'b1; lrckIn = 1'b1; sdInSlave = 1'b0;
    txValid = 1'b0; txLeft = '0; txRight = '0; rxReady = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(rxValid == 1'b0, "R9 rxValid", {31'b0, rxValid}, 32'h0);
    check(underrun == 1'b0, "R9 underrun", {31'b0, underrun}, 32'h0);
    check(txReady == 1'b1, "R9 txReady", {31'b0, txReady}, 32'h1);
    check({bclkOut, lrckOut} == 2'b00, "R9 clocks", {30'b0, bclkOut, lrckOut}, 32'h0);
    rstN = 1'b1;

    // Table walk: send all pairs in master mode with sdOut looped to sdIn.
    fork
      for (int i = 0; i < N_VEC; i++) push(VEC[i]);
    join_none
    for (int j = 0; j < N_VEC; j++) begin
      while (!rxValid) @(negedge clk);
      check({rxLeft, rxRight} == VEC[j], "R4 loopback pair", {rxLeft, rxRight}, VEC[j]);
      @(negedge clk);
    end
    while (nFr < 9) @(negedge clk);

    // R1: clock ratios
    check(bPer == 8, "R1 bit clock period", bPer, 8);
    check(lPer == 256, "R1 word clock period", lPer, 256);
    check(lHigh == 128, "R1 word clock high time", lHigh, 128);
    check(mclkOe == 1'b1, "R1 mclkOe", {31'b0, mclkOe}, 32'h1);
    // R3 / R6: decoded frames, last two repeat the final pair
    for (int k = 0; k < 7; k++) begin
      w = '0;
      for (int b = 0; b < 32; b++) w = {w[30:0], bitBuf[frameIdx[k] + 1 + b]};
      if (k < N_VEC) check(w == VEC[k], "R3 serial frame", w, VEC[k]);
      else           check(w == VEC[N_VEC-1], "R6 repeated frame", w, VEC[N_VEC-1]);
    end
    check(undAtF4 == 1'b0, "R6 no underrun while fed", {31'b0, undAtF4}, 32'h0);
    check(underrun == 1'b1, "R6 underrun set", {31'b0, underrun}, 32'h1);

    // Slave mode
    @(negedge clk);
    rstN = 1'b0; masterMode = 1'b0; rxReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(mclkOe == 1'b0, "R2 mclkOe", {31'b0, mclkOe}, 32'h0);
    check(underrun == 1'b0, "R9 underrun cleared", {31'b0, underrun}, 32'h0);
    fork
      begin
        logic [31:0] pr, prevR;
        prevR = '0;
        slot(1'b1, 1'b0);
        slot(1'b1, 1'b0);
        for (int f = 0; f < 4; f++) begin
          pr = (f < 3) ? SLV[f] : 32'h0;
          for (int s = 0; s < 32; s++) begin
            if (s == 0)       slot(1'b0, prevR[0]);
            else if (s < 16)  slot(1'b0, pr[16 + 16 - s]);
            else if (s == 16) slot(1'b1, pr[16]);
            else              slot(1'b1, pr[32 - s]);
          end
          prevR = pr;
        end
        genDone = 1'b1;
      end
    join_none
    while (!rxValid) @(negedge clk);
    check({rxLeft, rxRight} == SLV[0], "R8 slave pair", {rxLeft, rxRight}, SLV[0]);
    held = {rxLeft, rxRight};
    repeat (30) @(negedge clk);
    check(rxValid && {rxLeft, rxRight} == held, "R7 held without rxReady",
          {rxLeft, rxRight}, held);
    check({bclkOut, lrckOut} == 2'b00, "R2 clock outputs low", {30'b0, bclkOut, lrckOut}, 32'h0);
    rxReady = 1'b1;
    @(negedge clk);
    check(rxValid == 1'b0, "R7 taken on rxReady", {31'b0, rxValid}, 32'h0);
    for (int j = 1; j < 3; j++) begin
      while (!rxValid) @(negedge clk);
      check({rxLeft, rxRight} == SLV[j], "R8 slave pair", {rxLeft, rxRight}, SLV[j]);
      @(negedge clk);
    end
    while (!genDone) @(negedge clk);
    check(underrun == 1'b1, "R6 slave underrun without tx", {31'b0, underrun}, 32'h1);
    check(txReady == 1'b1, "R5 txReady idle", {31'b0, txReady}, 32'h1);
    finishRun();
  end
endmodule